// File: doc/BRIEF.md
# Radio SPI Transaction Framer

This block sits between two on-chip requesters and a byte-wide SPI shift engine that talks to a packet radio. Each requester asks for one of five operations: write a configuration register, read one, issue a command strobe, load the radio's transmit buffer, or drain its receive buffer. The framer builds the command byte and selects chip select. It then steps every byte through the shift engine, one start/done handshake per byte. Register writes and reads carry a fixed two-byte payload. A strobe is a lone byte. Buffer loads and drains are open-ended streams, and the session stays open as long as chip select is held low.

The byte the radio returns while the command byte is shifting is a status byte, and it is kept in a status register. Bytes returned during a drain go out on a valid/ready stream. Payload for a load comes in on a second valid/ready stream that carries a last flag. When both requesters ask at once, the grant alternates between them. A session always runs to its end before the next one starts, and chip select rests high for a minimum number of clocks between sessions.

Top module: `radio_spi_framer`

## Requirements
- R1: The first byte of a session is {1'b0, rw, addr[5:0]}, with rw = 1 for register read and receive drain and rw = 0 otherwise; the kind codes are 0 register write, 1 register read, 2 strobe, 3 transmit load and 4 receive drain.
- R2: A register write shifts exactly three bytes: the command, wdata[15:8], then wdata[7:0]; the bytes returned during it leave the read result unchanged.
- R3: A strobe shifts exactly one byte, and address 0 yields the byte 0x00, which serves only to refresh status.
- R4: The byte returned while the first byte of any session shifts is stored as the status output and held until the next session's first byte completes.
- R5: A transmit load shifts the command byte, then each payload byte in arrival order up to and including the one flagged last, with chip select low without a break for the whole session.
- R6: A receive drain of length N shifts the command byte and then N bytes of 0x00, and offers each byte returned after the first on the drain stream in order; while a drain byte waits for its ready, no further byte is started; N = 0 shifts only the command byte.
- R7: A register read shifts the command byte then two 0x00 bytes, and the read result becomes {second returned byte, third returned byte}.
- R8: When both requesters are waiting, the grant goes to the one not served by the previous grant (after reset the transmit side wins the first contest); a lone requester is always served; at most one grant is given per cycle.
- R9: Chip select stays high for at least 2 clocks between sessions, and a byte start is only issued while chip select is low.
- R10: Done is high for exactly one clock at the end of each session, while chip select is still low, with done_src giving the served side (0 transmit, 1 receive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t_req | input | 1 | Transmit-side request, held until acknowledged |
| t_kind | input | 3 | Transmit-side operation code |
| t_addr | input | 6 | Transmit-side register, strobe or buffer address |
| t_wdata | input | 16 | Transmit-side register write data |
| t_len | input | 8 | Transmit-side drain length |
| t_ack | output | 1 | Transmit-side request taken at this edge |
| r_req | input | 1 | Receive-side request, held until acknowledged |
| r_kind | input | 3 | Receive-side operation code |
| r_addr | input | 6 | Receive-side address |
| r_wdata | input | 16 | Receive-side register write data |
| r_len | input | 8 | Receive-side drain length |
| r_ack | output | 1 | Receive-side request taken at this edge |
| pl_data | input | 8 | Transmit payload byte |
| pl_valid | input | 1 | Payload byte present |
| pl_last | input | 1 | Payload byte is the final one of the load |
| pl_ready | output | 1 | Framer takes the payload byte |
| dr_data | output | 8 | Drained byte |
| dr_valid | output | 1 | Drained byte present |
| dr_ready | input | 1 | Consumer takes the drained byte |
| rd_data | output | 16 | Result of the latest register read |
| status | output | 8 | Latest status byte |
| done | output | 1 | Session finishing pulse |
| done_src | output | 1 | Side served by the finishing session |
| cs_n | output | 1 | Active-low chip select |
| sh_start | output | 1 | Start shifting sh_tx |
| sh_tx | output | 8 | Byte to shift out |
| sh_done | input | 1 | Shift engine finished a byte |
| sh_rx | input | 8 | Byte shifted in |

## Verification
Every operation kind is run through a bench shift engine that returns a rising byte sequence, so a misplaced, missing or extra byte shows up as a wrong sent or returned value. A write follows a read to show that write-time bytes cannot reach the read result. Strobes at address 0 and elsewhere tell the status-only case apart from a real strobe. Drains of length three, zero, and two with a stalled consumer separate correct counting from off-by-one and a missing stall. Two requesters each fire twice back to back, so the grant order can only come out as t, r, t, r if the arbiter alternates; fixed priority would serve t twice first.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    // Operation codes carried on t_kind / r_kind
    typedef enum logic [2:0] {
        K_WR  = 3'd0,
        K_RD  = 3'd1,
        K_STB = 3'd2,
        K_TXL = 3'd3,
        K_RXD = 3'd4
    } kind_e;

    // Session controller states
    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_FETCH,
        S_PUSH,
        S_FIN
    } st_e;

    // Fields of a granted request kept for the whole session
    typedef struct packed {
        kind_e       kind;
        logic [15:0] wdata;
    } sess_t;
endpackage

// File: rtl/rsf_cmd_fmt.sv
// Builds the leading byte of a session from operation code and address.
// Assumes: read-direction operations are register read and buffer drain.
module rsf_cmd_fmt
    import rsf_pkg::*;
(
    input  kind_e       kind,
    input  logic [5:0]  addr,
    output logic [7:0]  cmd
);
    logic rw;

    // Direction bit: set for operations that fetch data from the radio
    always_comb begin
        rw  = (kind == K_RD) || (kind == K_RXD);
        cmd = {1'b0, rw, addr};
    end
endmodule

// File: rtl/rsf_arb.sv
// Two-way arbiter that alternates under contention.
// Assumes: en is high only when a new session may start.
module rsf_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic a_req,
    input  logic b_req,
    output logic gnt_a,
    output logic gnt_b
);
    logic last_b;
    logic pick_b;

    // Choose b when alone or when a was served last
    always_comb begin
        pick_b = b_req && (!a_req || !last_b);
        gnt_b  = en && pick_b;
        gnt_a  = en && a_req && !pick_b;
    end

    // Remember which side took the latest grant
    always_ff @(posedge clk) begin
        if (!rst_n)              last_b <= 1'b1;
        else if (gnt_a || gnt_b) last_b <= gnt_b;
    end

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_a, gnt_b}));
    // R8
    grant_a_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_a |-> a_req);
    // R8
    grant_b_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_b |-> b_req);
endmodule

// File: rtl/rsf_gap_timer.sv
// Counts idle clocks since chip select was released.
// Assumes: idle is high exactly while chip select is high.
module rsf_gap_timer #(
    parameter int GAP_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    output logic gap_ok
);
    localparam int CW = $clog2(GAP_MIN + 1);
    logic [CW-1:0] cnt;

    // Saturating count of consecutive idle clocks
    always_ff @(posedge clk) begin
        if (!rst_n || !idle)        cnt <= '0;
        else if (cnt != CW'(GAP_MIN)) cnt <= cnt + 1'b1;
    end

    // A grant in this cycle leaves chip select high for cnt+1 clocks
    always_comb gap_ok = idle && (cnt >= CW'(GAP_MIN - 1));
endmodule

// File: rtl/radio_spi_framer.sv
// Frames register, strobe and buffer sessions for an SPI radio and steps
// each byte through a start/done shift engine.
// Assumes: sh_done pulses once per sh_start; requests are held until ack;
// a transmit load carries at least one payload byte.
module radio_spi_framer
    import rsf_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int GAP_MIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             t_req,
    input  logic [2:0]       t_kind,
    input  logic [5:0]       t_addr,
    input  logic [15:0]      t_wdata,
    input  logic [LEN_W-1:0] t_len,
    output logic             t_ack,
    input  logic             r_req,
    input  logic [2:0]       r_kind,
    input  logic [5:0]       r_addr,
    input  logic [15:0]      r_wdata,
    input  logic [LEN_W-1:0] r_len,
    output logic             r_ack,
    input  logic [7:0]       pl_data,
    input  logic             pl_valid,
    input  logic             pl_last,
    output logic             pl_ready,
    output logic [7:0]       dr_data,
    output logic             dr_valid,
    input  logic             dr_ready,
    output logic [15:0]      rd_data,
    output logic [7:0]       status,
    output logic             done,
    output logic             done_src,
    output logic             cs_n,
    output logic             sh_start,
    output logic [7:0]       sh_tx,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx
);
    st_e              state;
    sess_t            sess;
    logic [LEN_W-1:0] rem;
    logic [1:0]       idx;
    logic             last_seen;
    logic [7:0]       byte_q;
    logic [7:0]       dr_q;
    logic [15:0]      rd_q;
    logic [7:0]       stat_q;
    logic             src_q;

    logic             gap_ok;
    logic             gnt_a;
    logic             gnt_b;
    kind_e            g_kind;
    logic [5:0]       g_addr;
    logic [15:0]      g_wdata;
    logic [LEN_W-1:0] g_len;
    logic [7:0]       g_cmd;

    rsf_gap_timer #(.GAP_MIN(GAP_MIN)) i_gap (
        .clk(clk), .rst_n(rst_n), .idle(state == S_IDLE), .gap_ok(gap_ok)
    );

    rsf_arb i_arb (
        .clk(clk), .rst_n(rst_n), .en(gap_ok),
        .a_req(t_req), .b_req(r_req), .gnt_a(gnt_a), .gnt_b(gnt_b)
    );

    // Route the fields of the side being granted
    always_comb begin
        g_kind  = gnt_b ? kind_e'(r_kind) : kind_e'(t_kind);
        g_addr  = gnt_b ? r_addr  : t_addr;
        g_wdata = gnt_b ? r_wdata : t_wdata;
        g_len   = gnt_b ? r_len   : t_len;
    end

    rsf_cmd_fmt i_cmd (.kind(g_kind), .addr(g_addr), .cmd(g_cmd));

    // Session sequencer: grant, byte issue, completion handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            sess      <= '{kind: K_STB, wdata: '0};
            rem       <= '0;
            idx       <= '0;
            last_seen <= 1'b0;
            byte_q    <= '0;
            dr_q      <= '0;
            rd_q      <= '0;
            stat_q    <= '0;
            src_q     <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (gnt_a || gnt_b) begin
                    sess      <= '{kind: g_kind, wdata: g_wdata};
                    rem       <= g_len;
                    idx       <= '0;
                    last_seen <= 1'b0;
                    byte_q    <= g_cmd;
                    src_q     <= gnt_b;
                    state     <= S_ISSUE;
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: if (sh_done) begin
                    if (idx != 2'd3) idx <= idx + 2'd1;
                    if (idx == 2'd0) stat_q <= sh_rx;
                    case (sess.kind)
                        K_WR: begin
                            byte_q <= (idx == 2'd0) ? sess.wdata[15:8] : sess.wdata[7:0];
                            state  <= (idx == 2'd2) ? S_FIN : S_ISSUE;
                        end
                        K_RD: begin
                            byte_q <= 8'h00;
                            if (idx == 2'd1) rd_q[15:8] <= sh_rx;
                            if (idx == 2'd2) rd_q[7:0]  <= sh_rx;
                            state  <= (idx == 2'd2) ? S_FIN : S_ISSUE;
                        end
                        K_TXL: state <= last_seen ? S_FIN : S_FETCH;
                        K_RXD: begin
                            byte_q <= 8'h00;
                            if (idx != 2'd0) begin
                                dr_q  <= sh_rx;
                                state <= S_PUSH;
                            end else begin
                                state <= (rem == '0) ? S_FIN : S_ISSUE;
                            end
                        end
                        default: state <= S_FIN;
                    endcase
                end
                S_FETCH: if (pl_valid) begin
                    byte_q    <= pl_data;
                    last_seen <= pl_last;
                    state     <= S_ISSUE;
                end
                S_PUSH: if (dr_ready) begin
                    rem   <= rem - 1'b1;
                    state <= (rem == LEN_W'(1)) ? S_FIN : S_ISSUE;
                end
                S_FIN: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Port drive derived from state and held registers
    always_comb begin
        cs_n     = (state == S_IDLE);
        sh_start = (state == S_ISSUE);
        sh_tx    = byte_q;
        pl_ready = (state == S_FETCH);
        dr_valid = (state == S_PUSH);
        dr_data  = dr_q;
        done     = (state == S_FIN);
        done_src = src_q;
        rd_data  = rd_q;
        status   = stat_q;
        t_ack    = gnt_a;
        r_ack    = gnt_b;
    end

    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);
    // R9
    start_in_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !cs_n);
    // R10
    done_ends_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cs_n ##1 cs_n));
    // R4
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_done |=> $stable(status));
    // R6
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_data) && !sh_start));
    // R5
    payload_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> !cs_n);
endmodule

// File: tb/test_radio_spi_framer.sv
module test_radio_spi_framer;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic t_req = 0, r_req = 0;
    logic [2:0] t_kind = 0, r_kind = 0;
    logic [5:0] t_addr = 0, r_addr = 0;
    logic [15:0] t_wdata = 0, r_wdata = 0;
    logic [7:0] t_len = 0, r_len = 0;
    logic t_ack, r_ack;
    logic [7:0] pl_data = 0;
    logic pl_valid = 0, pl_last = 0, pl_ready;
    logic [7:0] dr_data;
    logic dr_valid, dr_ready = 1;
    logic [15:0] rd_data;
    logic [7:0] status;
    logic done, done_src, cs_n, sh_start;
    logic [7:0] sh_tx;
    logic sh_done = 0;
    logic [7:0] sh_rx = 0;

    int checks = 0, fails = 0, cyc = 0;
    int cs_falls = 0, hi_run = 100;
    logic prev_cs = 1'b1;
    logic [7:0] sent[$], ret[$], got[$], pl_q[$];
    logic [7:0] rx_next = 8'h31;
    bit order[$];

    radio_spi_framer i_radio_spi_framer (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            summary();
        end
    end

    // Shift engine model: two-clock latency, rising return sequence
    initial begin
        forever begin
            @(negedge clk);
            while (sh_start === 1'b1) begin
                sent.push_back(sh_tx);
                @(negedge clk);
                @(negedge clk);
                sh_rx = rx_next;
                ret.push_back(rx_next);
                rx_next = rx_next + 8'h0B;
                sh_done = 1'b1;
                @(negedge clk);
                sh_done = 1'b0;
            end
        end
    end

    // Payload source from pl_q
    initial begin
        forever begin
            @(negedge clk);
            if (pl_q.size() > 0) begin
                pl_valid = 1'b1;
                pl_data  = pl_q[0];
                pl_last  = (pl_q.size() == 1);
                if (pl_ready) begin
                    @(posedge clk);
                    void'(pl_q.pop_front());
                end
            end else begin
                pl_valid = 1'b0;
                pl_last  = 1'b0;
            end
        end
    end

    // Per-clock monitor: drain capture, chip-select gap, start inside session
    always @(negedge clk) begin
        if (rst_n) begin
            if (dr_valid && dr_ready) got.push_back(dr_data);
            if (!cs_n && prev_cs) begin
                cs_falls++;
                chk("R9 cs high gap", hi_run >= 2, 1);
            end
            if (sh_start) chk("R9 start while cs low", cs_n, 0);
            if (done) chk("R10 done while cs low", cs_n, 0);
        end
        hi_run  = cs_n ? hi_run + 1 : 0;
        prev_cs = cs_n;
    end

    task automatic request(input bit side, input logic [2:0] k, input logic [5:0] a,
                           input logic [15:0] w, input logic [7:0] n);
        @(negedge clk);
        if (side) begin r_kind = k; r_addr = a; r_wdata = w; r_len = n; r_req = 1; end
        else      begin t_kind = k; t_addr = a; t_wdata = w; t_len = n; t_req = 1; end
        #1;
        while (!(side ? r_ack : t_ack)) begin @(negedge clk); #1; end
        @(posedge clk);
        order.push_back(side);
        @(negedge clk);
        if (side) r_req = 0; else t_req = 0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic clear();
        sent.delete(); ret.delete(); got.delete();
    endtask

    task automatic run(input bit side, input logic [2:0] k, input logic [5:0] a,
                       input logic [15:0] w, input logic [7:0] n);
        clear();
        request(side, k, a, w, n);
        wait_done();
        chk("R10 done side", done_src, side);
        @(negedge clk);
        chk("R10 done one clock", done, 0);
    endtask

    initial begin
        logic [15:0] rd_before;
        int n0, f0;
        repeat (4) @(negedge clk);
        chk("R9 reset cs_n", cs_n, 1);
        chk("R10 reset done", done, 0);
        chk("R4 reset status", status, 0);
        chk("R7 reset rd_data", rd_data, 0);
        chk("R9 reset start", sh_start, 0);
        rst_n = 1'b1;

        // R7 register read from receive side
        run(1, 3'd1, 6'h2A, 16'h0, 8'd0);
        chk("R7 byte count", sent.size(), 3);
        chk("R1 read cmd", sent[0], 8'h6A);
        chk("R7 dummy 1", sent[1], 8'h00);
        chk("R7 dummy 2", sent[2], 8'h00);
        chk("R7 result", rd_data, {ret[1], ret[2]});
        chk("R4 status read", status, ret[0]);

        // R2 register write; read result must stay
        rd_before = rd_data;
        run(0, 3'd0, 6'h15, 16'hBEEF, 8'd0);
        chk("R2 byte count", sent.size(), 3);
        chk("R1 write cmd", sent[0], 8'h15);
        chk("R2 high byte", sent[1], 8'hBE);
        chk("R2 low byte", sent[2], 8'hEF);
        chk("R2 rd unchanged", rd_data, rd_before);
        chk("R4 status write", status, ret[0]);

        // R3 status-only strobe and a real strobe
        run(0, 3'd2, 6'h00, 16'h0, 8'd0);
        chk("R3 nop count", sent.size(), 1);
        chk("R3 nop byte", sent[0], 8'h00);
        chk("R4 status nop", status, ret[0]);
        run(1, 3'd2, 6'h03, 16'h0, 8'd0);
        chk("R3 strobe count", sent.size(), 1);
        chk("R3 strobe byte", sent[0], 8'h03);

        // R5 transmit load of four bytes
        pl_q = '{8'h11, 8'h22, 8'h33, 8'h44};
        f0 = cs_falls;
        run(0, 3'd3, 6'h3E, 16'h0, 8'd0);
        chk("R5 byte count", sent.size(), 5);
        chk("R1 load cmd", sent[0], 8'h3E);
        for (int i = 0; i < 4; i++) chk("R5 payload order", sent[i+1], 8'h11 * (i + 1));
        chk("R5 one cs low period", cs_falls - f0, 1);
        chk("R4 status load", status, ret[0]);

        // R6 drain of three bytes
        run(1, 3'd4, 6'h3F, 16'h0, 8'd3);
        chk("R6 byte count", sent.size(), 4);
        chk("R1 drain cmd", sent[0], 8'h7F);
        for (int i = 1; i < 4; i++) chk("R6 dummy byte", sent[i], 8'h00);
        chk("R6 drained count", got.size(), 3);
        for (int i = 0; i < 3; i++) chk("R6 drained data", got[i], ret[i+1]);

        // R6 zero-length drain
        run(1, 3'd4, 6'h3F, 16'h0, 8'd0);
        chk("R6 empty count", sent.size(), 1);
        chk("R6 empty no data", got.size(), 0);

        // R6 stalled consumer
        clear();
        dr_ready = 1'b0;
        request(1, 3'd4, 6'h3F, 16'h0, 8'd2);
        do @(negedge clk); while (!dr_valid);
        n0 = sent.size();
        repeat (5) @(negedge clk);
        chk("R6 no start while stalled", sent.size(), n0);
        chk("R6 data held valid", dr_valid, 1);
        dr_ready = 1'b1;
        wait_done();
        chk("R6 stalled count", got.size(), 2);
        for (int i = 0; i < 2; i++) chk("R6 stalled data", got[i], ret[i+1]);

        // R8 contention: last grant went to receive side
        @(negedge clk);
        order.delete();
        fork
            begin request(0, 3'd2, 6'h01, 16'h0, 8'd0); request(0, 3'd2, 6'h02, 16'h0, 8'd0); end
            begin request(1, 3'd2, 6'h05, 16'h0, 8'd0); request(1, 3'd2, 6'h06, 16'h0, 8'd0); end
        join
        wait_done();
        chk("R8 grant count", order.size(), 4);
        for (int i = 0; i < 4; i++) chk("R8 alternating order", order[i], i % 2);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule